// File: doc/BRIEF.md
# MSI Event Queue Writer

This block turns incoming message-signalled interrupts into entries in ring buffers kept in host memory. Each ring is tied to its own interrupt output. When an MSI arrives, the block picks the target ring from the low bits of the MSI data word, using a small table that software programs. It then writes a 32-bit entry at that ring's current tail slot through a request/acknowledge memory-write port. The MSI data occupies the lower half of the entry.

The tail pointer belongs to the hardware. It moves forward only after the memory write has been acknowledged. The ring's interrupt follows from that tail update, so software never sees an interrupt for an entry that has not yet landed in memory. The head pointer belongs to software, which writes it after draining entries. The interrupt line stays high while the two pointers differ.

When a ring is full, the incoming MSI is held off with back-pressure and is not lost. Software sets each ring's base address, head pointer and map entries through a simple register write port. It reads any ring's tail through a combinational read port.

Top module: `msi_evq_writer`

## Requirements
- R1: After reset every tail and head pointer is 0, every irq bit is low, mem_req is low and the tail read port returns 0 for every ring.
- R2: An MSI goes to ring map[msi_data[MAP_BITS-1:0]]. Map entry i resets to i mod NQ, and a register write of kind 2 sets entry reg_idx to reg_wdata[QW-1:0].
- R3: The entry for an MSI is written at address base + 4*tail of its ring. Its data is {16'h0000, msi_data}: the MSI word is in bits 15:0 and bits 31:16 are zero.
- R4: Once raised, mem_req stays high with mem_addr and mem_wdata unchanged until mem_ack is sampled high.
- R5: A ring's tail moves forward by one, modulo DEPTH (64), in the cycle after the clock edge that samples mem_ack. It does not move while the write is pending. From DEPTH-1 it wraps to 0.
- R6: irq[q] is high exactly when head and tail of ring q differ. So it rises only after the tail update, and it falls one cycle after software writes a head value equal to the tail.
- R7: A ring is full when tail+1 equals head modulo DEPTH. An MSI aimed at a full ring sees msi_ready low and is neither written nor dropped. It is accepted once a head write frees a slot.
- R8: tail_rd returns, combinationally, the tail of the ring selected by tail_rd_sel.
- R9: A register write with reg_kind 0 sets the base of ring reg_idx[QW-1:0] to reg_wdata. Kind 1 sets its head to reg_wdata[PTR_W-1:0]. Only one MSI is in flight at a time: msi_ready is low while mem_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Incoming MSI present |
| msi_data | input | 16 | MSI data word |
| msi_ready | output | 1 | MSI accepted on this edge when valid |
| mem_req | output | 1 | Entry write request |
| mem_addr | output | ADDR_W | Byte address of the entry |
| mem_wdata | output | 32 | Entry word |
| mem_ack | input | 1 | Entry write complete |
| reg_we | input | 1 | Register write strobe |
| reg_kind | input | 2 | 0 base, 1 head, 2 map entry |
| reg_idx | input | MAP_BITS | Ring index (low QW bits) or map entry index |
| reg_wdata | input | ADDR_W | Register write value |
| tail_rd_sel | input | QW | Ring selected for tail read |
| tail_rd | output | PTR_W | Tail of the selected ring |
| irq | output | NQ | One interrupt level per ring |

## Verification
An MSI is accepted on the rising edge where msi_valid and msi_ready are both high. mem_req appears in the next cycle. The ring's tail and its irq change in the cycle after the edge that samples mem_ack. A head write changes irq in the cycle after its write edge.

The bench drives inputs and samples outputs on falling edges. The memory model acknowledges on a falling edge and compares the entry against the scoreboard at that moment. Each pointer or irq check waits for the drain point one falling edge after the acknowledge, so every register on the path has already updated. During a held acknowledge, the bench checks the tail and irq several cycles after acceptance to show that nothing moves early.

// File: rtl/msi_evq_pkg.sv
package msi_evq_pkg;
   localparam int MSI_W   = 16;
   localparam int ENTRY_W = 32;

   typedef enum logic [1:0] {
      REG_BASE = 2'd0,
      REG_HEAD = 2'd1,
      REG_MAP  = 2'd2
   } reg_kind_e;

   typedef enum logic {
      ENG_IDLE  = 1'b0,
      ENG_WRITE = 1'b1
   } eng_state_e;
endpackage

// File: rtl/msi_evq_ring.sv
module msi_evq_ring #(
   parameter int ADDR_W = 32,
   parameter int PTR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic [ADDR_W-1:0] base_in,
   input  logic              head_we,
   input  logic [PTR_W-1:0]  head_in,
   input  logic              adv,
   output logic [ADDR_W-1:0] base,
   output logic [PTR_W-1:0]  tail,
   output logic [PTR_W-1:0]  head,
   output logic              full,
   output logic              pending
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base <= '0;
         tail <= '0;
         head <= '0;
      end else begin
         if (base_we) base <= base_in;
         if (head_we) head <= head_in;
         if (adv)     tail <= tail + 1'b1;
      end
   end

   always_comb begin
      full    = (PTR_W'(tail + 1'b1) == head);
      pending = (tail != head);
   end
endmodule

// File: rtl/msi_evq_map.sv
module msi_evq_map #(
   parameter int NQ       = 4,
   parameter int MAP_BITS = 2,
   parameter int QW       = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [MAP_BITS-1:0] widx,
   input  logic [QW-1:0]       wq,
   input  logic [MAP_BITS-1:0] ridx,
   output logic [QW-1:0]       rq
);
   localparam int ENTRIES = 1 << MAP_BITS;

   logic [QW-1:0] tbl [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)                          tbl[e] <= QW'(e % NQ);
         else if (we && widx == MAP_BITS'(e)) tbl[e] <= wq;
      end
   end

   assign rq = tbl[ridx];
endmodule

// File: rtl/msi_evq_engine.sv
module msi_evq_engine
   import msi_evq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PTR_W  = 6,
   parameter int QW     = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               msi_valid,
   input  logic [MSI_W-1:0]   msi_data,
   output logic               msi_ready,
   input  logic [QW-1:0]      tgt_q,
   input  logic               tgt_full,
   input  logic [ADDR_W-1:0]  tgt_base,
   input  logic [PTR_W-1:0]   tgt_tail,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [ENTRY_W-1:0] mem_wdata,
   input  logic               mem_ack,
   output logic               adv,
   output logic [QW-1:0]      cur_q
);
   eng_state_e state;
   logic       accept;

   always_comb begin
      msi_ready = (state == ENG_IDLE) && !tgt_full;
      accept    = msi_valid && msi_ready;
      mem_req   = (state == ENG_WRITE);
      adv       = mem_req && mem_ack;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ENG_IDLE;
         mem_addr  <= '0;
         mem_wdata <= '0;
         cur_q     <= '0;
      end else begin
         case (state)
            ENG_IDLE: if (accept) begin
               state     <= ENG_WRITE;
               mem_addr  <= tgt_base + ({{(ADDR_W-PTR_W){1'b0}}, tgt_tail} << 2);
               mem_wdata <= {{(ENTRY_W-MSI_W){1'b0}}, msi_data};
               cur_q     <= tgt_q;
            end
            ENG_WRITE: if (mem_ack) state <= ENG_IDLE;
            default:   state <= ENG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/msi_evq_writer.sv
module msi_evq_writer
   import msi_evq_pkg::*;
#(
   parameter int NQ       = 4,
   parameter int DEPTH    = 64,
   parameter int ADDR_W   = 32,
   parameter int MAP_BITS = 2,
   localparam int QW      = $clog2(NQ),
   localparam int PTR_W   = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                msi_valid,
   input  logic [15:0]         msi_data,
   output logic                msi_ready,
   output logic                mem_req,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [31:0]         mem_wdata,
   input  logic                mem_ack,
   input  logic                reg_we,
   input  logic [1:0]          reg_kind,
   input  logic [MAP_BITS-1:0] reg_idx,
   input  logic [ADDR_W-1:0]   reg_wdata,
   input  logic [QW-1:0]       tail_rd_sel,
   output logic [PTR_W-1:0]    tail_rd,
   output logic [NQ-1:0]       irq
);
   if (NQ < 2 || (1 << QW) != NQ) begin : g_bad_nq
      $error("NQ must be a power of two and at least 2");
   end
   if (DEPTH < 4 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 4");
   end
   if (MAP_BITS < QW) begin : g_bad_map
      $error("MAP_BITS must be at least QW");
   end
   if (ADDR_W <= PTR_W + 2) begin : g_bad_addr
      $error("ADDR_W too narrow for ring offsets");
   end

   logic [ADDR_W-1:0]     base_a [NQ];
   logic [PTR_W-1:0]      tail_a [NQ];
   logic [PTR_W-1:0]      head_a [NQ];
   logic [NQ-1:0]         full_v;
   logic [NQ*PTR_W-1:0]   tail_flat;
   logic [QW-1:0]         tgt_q;
   logic [QW-1:0]         cur_q;
   logic                  adv;
   logic [QW-1:0]         reg_ring;

   assign reg_ring = reg_idx[QW-1:0];

   msi_evq_map #(.NQ(NQ), .MAP_BITS(MAP_BITS), .QW(QW)) map_i (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (reg_we && reg_kind == REG_MAP),
      .widx (reg_idx),
      .wq   (reg_wdata[QW-1:0]),
      .ridx (msi_data[MAP_BITS-1:0]),
      .rq   (tgt_q)
   );

   for (genvar q = 0; q < NQ; q++) begin : g_ring
      msi_evq_ring #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) ring_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .base_we(reg_we && reg_kind == REG_BASE && reg_ring == QW'(q)),
         .base_in(reg_wdata),
         .head_we(reg_we && reg_kind == REG_HEAD && reg_ring == QW'(q)),
         .head_in(reg_wdata[PTR_W-1:0]),
         .adv    (adv && cur_q == QW'(q)),
         .base   (base_a[q]),
         .tail   (tail_a[q]),
         .head   (head_a[q]),
         .full   (full_v[q]),
         .pending(irq[q])
      );
      assign tail_flat[q*PTR_W +: PTR_W] = tail_a[q];
   end

   msi_evq_engine #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .QW(QW)) eng_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .msi_valid(msi_valid),
      .msi_data (msi_data),
      .msi_ready(msi_ready),
      .tgt_q    (tgt_q),
      .tgt_full (full_v[tgt_q]),
      .tgt_base (base_a[tgt_q]),
      .tgt_tail (tail_a[tgt_q]),
      .mem_req  (mem_req),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_ack  (mem_ack),
      .adv      (adv),
      .cur_q    (cur_q)
   );

   assign tail_rd = tail_a[tail_rd_sel];
endmodule

// File: rtl/msi_evq_chk.sv
module msi_evq_chk #(
   parameter int NQ     = 4,
   parameter int PTR_W  = 6,
   parameter int ADDR_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                msi_ready,
   input logic                mem_req,
   input logic                mem_ack,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [31:0]         mem_wdata,
   input logic                reg_we,
   input logic [NQ-1:0]       irq,
   input logic [NQ*PTR_W-1:0] tail_flat
);
   // R4: request held steady until acknowledged
   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

   // R3: reserved upper half written as zero
   p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_wdata[31:16] == 16'h0);

   // R5: a tail only moves after a completed write
   p_tail_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tail_flat) |-> $past(mem_req && mem_ack));

   // R9: one MSI in flight
   p_single_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !msi_ready);

   // R6: an interrupt rises only after a tail update or a head write
   for (genvar q = 0; q < NQ; q++) begin : g_irq
      p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq[q]) |-> $past((mem_req && mem_ack) || reg_we));
   end
endmodule

bind msi_evq_writer msi_evq_chk #(.NQ(NQ), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .msi_ready(msi_ready),
   .mem_req  (mem_req),
   .mem_ack  (mem_ack),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata),
   .reg_we   (reg_we),
   .irq      (irq),
   .tail_flat(tail_flat)
);

// File: tb/msi_evq_writer_tb_top.sv
`timescale 1ns/1ps
module msi_evq_writer_tb_top;
   localparam int NQ = 4, DEPTH = 64, ADDR_W = 32, MAP_BITS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msi_valid = 1'b0;
   logic [15:0] msi_data = '0;
   logic        msi_ready;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_kind = '0;
   logic [1:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [1:0]  tail_rd_sel = '0;
   logic [5:0]  tail_rd;
   logic [3:0]  irq;

   int checks = 0, errors = 0;
   bit hold_ack = 0;
   int lat = 0;
   logic [63:0] sb [$];
   logic [31:0] base_m [NQ];
   int          tail_m [NQ];
   int          map_m  [4];

   always #5 clk = ~clk;

   msi_evq_writer #(.NQ(NQ), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .MAP_BITS(MAP_BITS)) dut_i (
      .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_data(msi_data),
      .msi_ready(msi_ready), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .reg_we(reg_we),
      .reg_kind(reg_kind), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .tail_rd_sel(tail_rd_sel), .tail_rd(tail_rd), .irq(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory model and monitor: ack on a falling edge, compare with scoreboard
   always @(negedge clk) begin
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && !hold_ack) begin
         if (lat >= 2) begin
            lat = 0;
            mem_ack = 1'b1;
            if (sb.size() == 0) chk("R3 unexpected entry write", {mem_addr, mem_wdata}, 64'h0);
            else chk("R3 entry address/data", {mem_addr, mem_wdata}, sb.pop_front());
         end else lat++;
      end
   end

   task automatic reg_write(input logic [1:0] kind, input logic [1:0] idx, input logic [31:0] d);
      reg_we = 1'b1; reg_kind = kind; reg_idx = idx; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic send(input logic [15:0] d);
      int q;
      bit ok;
      q = map_m[d[1:0]];
      msi_valid = 1'b1; msi_data = d;
      ok = 0;
      while (!ok) begin
         #1;
         if (msi_ready) ok = 1;
         else @(negedge clk);
      end
      sb.push_back({base_m[q] + 32'(4 * tail_m[q]), 16'h0, d});
      tail_m[q] = (tail_m[q] + 1) % DEPTH;
      @(posedge clk);
      @(negedge clk);
      msi_valid = 1'b0;
   endtask

   task automatic drain();
      do @(negedge clk); while (sb.size() != 0 || mem_req);
   endtask

   task automatic chk_tail(input string req, input int q);
      tail_rd_sel = 2'(q);
      #1;
      chk(req, 64'(tail_rd), 64'(tail_m[q]));
   endtask

   initial begin
      for (int q = 0; q < NQ; q++) tail_m[q] = 0;
      for (int e = 0; e < 4; e++) map_m[e] = e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 / R8: reset state
      chk("R1 irq after reset", 64'(irq), 64'h0);
      chk("R1 mem_req after reset", 64'(mem_req), 64'h0);
      for (int q = 0; q < NQ; q++) chk_tail("R1 R8 tail after reset", q);

      // R9: bases; R2: map
      for (int q = 0; q < NQ; q++) begin
         base_m[q] = 32'h1000 * (q + 1);
         reg_write(2'd0, 2'(q), base_m[q]);
      end
      map_m[0] = 2; map_m[1] = 1; map_m[2] = 0; map_m[3] = 3;
      for (int e = 0; e < 4; e++) reg_write(2'd2, 2'(e), 32'(map_m[e]));

      // R2 R3 R5 R6: single entry into ring 2
      send(16'h1230);
      drain();
      chk_tail("R5 tail after one write", 2);
      chk("R6 irq after first entry", 64'(irq), 64'h4);

      send(16'hABC1);
      send(16'h0002);
      send(16'hFFFF);
      drain();
      for (int q = 0; q < NQ; q++) chk_tail("R2 R5 tails after mapped writes", q);
      chk("R6 irq all rings pending", 64'(irq), 64'hF);

      // R6: head catches up
      reg_write(2'd1, 2'd2, 32'd1);
      chk("R6 irq drops when head==tail", 64'(irq), 64'hB);
      reg_write(2'd1, 2'd1, 32'd0);
      chk("R6 irq stays while head!=tail", 64'(irq), 64'hB);

      // R4 R5 R6 R9: held acknowledge
      hold_ack = 1;
      send(16'h0004);
      repeat (5) @(negedge clk);
      chk("R4 mem_req held", 64'(mem_req), 64'h1);
      chk("R4 address held", 64'(mem_addr), 64'h3004);
      chk("R9 no accept while busy", 64'(msi_ready), 64'h0);
      tail_rd_sel = 2'd2; #1;
      chk("R5 tail frozen while pending", 64'(tail_rd), 64'h1);
      chk("R6 irq low before completion", 64'(irq[2]), 64'h0);
      hold_ack = 0;
      drain();
      chk_tail("R5 tail after release", 2);
      chk("R6 irq after release", 64'(irq[2]), 64'h1);

      // R7: fill ring 0 (tail 1, head 0) up to full
      for (int i = 0; i < 62; i++) send(16'((i << 2) | 2));
      drain();
      chk_tail("R7 tail at full point", 0);
      msi_valid = 1'b1; msi_data = 16'h5552;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (i == 7) begin
            chk("R7 ready low when full", 64'(msi_ready), 64'h0);
            chk("R7 no write when full", 64'(mem_req), 64'h0);
         end
      end
      reg_write(2'd1, 2'd0, 32'd5);
      send(16'h5552);
      drain();
      chk_tail("R5 R7 tail wraps to 0", 0);
      reg_write(2'd1, 2'd0, 32'd0);
      chk("R6 irq ring0 drops", 64'(irq[0]), 64'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule